// File: doc/BRIEF.md
# Scan-Chain Command Front-End

This block is an APB slave that feeds a serial scan-chain engine. Software writes command bytes through one of four FIFO windows, each moving one to four bytes per bus access, into a four-byte command queue. The engine drains that queue one byte at a time over a valid/ready stream. Bytes coming back from the engine are collected in a four-byte response queue, and software reads them back through the same four windows. When a window cannot move all of its bytes at once, the bus access waits with PREADY low. It never moves part of its bytes.

Next to the queues there are three more pieces. A status word reports both queue occupancies and the engine's activity. A chain-select register picks at most one of four I/O chains or the JTAG chain. A test-reset control bit drives an active-low reset toward the JTAG chain, but only while that chain is selected. A write to the chain-select register is refused with PSLVERR when the engine is not idle or when it names more than one chain. A response byte that arrives while the response queue is full is dropped, and a sticky flag records the loss.

Top module: `scan_fe`

## Requirements
- R1: After reset, the following all hold: the status word and the chain-select register read 0, `test_rst_n` is high, `cmd_valid` is low, `rsp_ovf` is low, and no chain is enabled.
- R2: Command bytes leave on `cmd_data` in the order they were pushed, one byte per cycle in which `cmd_valid` and `cmd_ready` are both high. While `cmd_valid` is high and `cmd_ready` is low, `cmd_data` and `cmd_valid` stay unchanged.
- R3: A write to word offset 0x10, 0x14, 0x18 or 0x1C pushes 1, 2, 3 or 4 bytes of PWDATA into the command queue. Bits [7:0] go first and higher bytes follow in ascending order. Write data above the alias's byte count is discarded.
- R4: A command-queue write whose byte count exceeds the free space holds PREADY low and pushes nothing. It completes, pushing all of its bytes together, once enough space has drained.
- R5: A read of offset 0x10, 0x14, 0x18 or 0x1C pops 1, 2, 3 or 4 response bytes. The oldest byte lands in PRDATA[7:0] and unused upper bits read 0. The read holds PREADY low until all of its bytes are present.
- R6: The status word at offset 0x0 holds four things. Bit 31 is the live `eng_active` input. Bits [30:28] hold the command-queue occupancy and bits [26:24] the response-queue occupancy. Bit 1 is the writable test-reset control. All other bits read 0, and writes to them are ignored.
- R7: The chain-select register at offset 0x4 has bits [3:0] for I/O chains 0 to 3 and bit 7 for the JTAG chain. These bits drive `io_chain_en` and `jtag_chain_en`. Other bits read 0 and are ignored on write. A write that sets more than one of these five bits completes with PSLVERR high and changes nothing.
- R8: A write to the chain-select register while `eng_active` is high or the command queue is not empty completes with PSLVERR high and changes nothing.
- R9: `test_rst_n` is low exactly when status bit 1 is 1 and the JTAG chain is selected. Otherwise it is high.
- R10: A response byte offered on `rsp_valid` while the response queue holds 4 bytes is dropped. This sets `rsp_ovf`, which stays high until reset.
- R11: Offsets 0x8 to 0xF, offsets above 0x1F, and offsets that are not word aligned read 0. Writes to them change nothing. Accesses to them complete without wait states and without PSLVERR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB transfer complete |
| pslverr | output | 1 | APB error (refused chain-select write) |
| eng_active | input | 1 | Engine is processing a command |
| cmd_valid | output | 1 | Command byte available |
| cmd_ready | input | 1 | Engine takes the command byte |
| cmd_data | output | 8 | Oldest command byte |
| rsp_valid | input | 1 | Response byte strobe |
| rsp_data | input | 8 | Response byte |
| rsp_ovf | output | 1 | Sticky response overflow flag |
| io_chain_en | output | NUM_IO | I/O chain enables |
| jtag_chain_en | output | 1 | JTAG chain enable |
| test_rst_n | output | 1 | Active-low test reset toward the JTAG chain |

## Verification
The assertions take two things for granted about the APB master. It keeps PSEL, PADDR, PWRITE and PWDATA steady from the setup cycle until the cycle where PREADY is seen high, and it raises PENABLE only after a setup cycle. The stall properties rely on this: a held access must keep asking for the same byte count. The bench drives every APB signal from one task that holds them until it has sampled PREADY. The engine side is driven only between clock edges, with `rsp_valid` as single-cycle pulses and `eng_active` changed only while no chain-select write is in flight.

// File: rtl/scan_fe_pkg.sv
package scan_fe_pkg;

    localparam int APB_DW         = 32;
    localparam int BYTES_PER_WORD = APB_DW / 8;

    // status word field positions (software decodes these)
    localparam int STAT_ACT_BIT  = 31;
    localparam int STAT_CMD_LSB  = 28;
    localparam int STAT_RSP_LSB  = 24;
    localparam int STAT_CNT_W    = 3;
    localparam int STAT_TRST_BIT = 1;

    // chain-select register: JTAG chain position
    localparam int EN_JTAG_BIT = 7;

    typedef struct packed {
        logic       stat;
        logic       chains;
        logic       fifo;
        logic [2:0] nbytes;
    } sfe_sel_t;

endpackage

// File: rtl/sfe_byte_fifo.sv
// Byte queue that accepts up to PUSH_B bytes and releases up to POP_B bytes
// per cycle. DEPTH must be a power of two and at least max(PUSH_B, POP_B).
// The caller guarantees room for pushes and data for pops.
module sfe_byte_fifo #(
    parameter int DEPTH  = 4,
    parameter int PUSH_B = 4,
    parameter int POP_B  = 1,
    localparam int AW  = $clog2(DEPTH),
    localparam int CW  = $clog2(DEPTH + 1),
    localparam int PNW = $clog2(PUSH_B + 1),
    localparam int QNW = $clog2(POP_B + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                push_en,
    input  logic [PNW-1:0]      push_n,
    input  logic [PUSH_B*8-1:0] push_data,
    input  logic                pop_en,
    input  logic [QNW-1:0]      pop_n,
    output logic [POP_B*8-1:0]  peek,
    output logic [CW-1:0]       count
);

    typedef struct packed {
        logic [DEPTH-1:0][7:0] mem;
        logic [AW-1:0]         rd_ptr;
        logic [CW-1:0]         cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (push_en) begin
            for (int k = 0; k < PUSH_B; k++) begin
                if (k < int'(push_n)) begin
                    st_d.mem[st_q.rd_ptr + AW'(st_q.cnt) + AW'(k)] = push_data[8*k +: 8];
                end
            end
        end
        if (pop_en) begin
            st_d.rd_ptr = st_q.rd_ptr + AW'(pop_n);
        end
        st_d.cnt = st_q.cnt
                 + (push_en ? CW'(push_n) : '0)
                 - (pop_en  ? CW'(pop_n)  : '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < POP_B; g++) begin : g_peek
        assign peek[8*g +: 8] = st_q.mem[st_q.rd_ptr + AW'(g)];
    end

    assign count = st_q.cnt;

endmodule

// File: rtl/sfe_addr_decode.sv
// Maps an APB byte address onto the register windows.
module sfe_addr_decode
    import scan_fe_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output sfe_sel_t          sel
);

    logic in_map;

    always_comb begin
        in_map     = (addr[ADDR_W-1:5] == '0) && (addr[1:0] == 2'b00);
        sel.stat   = in_map && (addr[4:2] == 3'd0);
        sel.chains = in_map && (addr[4:2] == 3'd1);
        sel.fifo   = in_map && addr[4];
        sel.nbytes = 3'(addr[3:2]) + 3'd1;
    end

endmodule

// File: rtl/scan_fe.sv
module scan_fe
    import scan_fe_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DEPTH  = 4,
    parameter int NUM_IO = 4,
    localparam int CW  = $clog2(DEPTH + 1),
    localparam int NBW = $clog2(BYTES_PER_WORD + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [APB_DW-1:0] pwdata,
    output logic [APB_DW-1:0] prdata,
    output logic              pready,
    output logic              pslverr,
    input  logic              eng_active,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [7:0]        cmd_data,
    input  logic              rsp_valid,
    input  logic [7:0]        rsp_data,
    output logic              rsp_ovf,
    output logic [NUM_IO-1:0] io_chain_en,
    output logic              jtag_chain_en,
    output logic              test_rst_n
);

    typedef struct packed {
        logic              trst;
        logic [NUM_IO-1:0] io_en;
        logic              jtag_en;
        logic              ovf;
    } ctl_st_t;

    ctl_st_t st_d, st_q;

    sfe_sel_t                 sel;
    logic [CW-1:0]            cmd_cnt;
    logic [CW-1:0]            rsp_cnt;
    logic [7:0]               cmd_peek;
    logic [APB_DW-1:0]        rsp_peek;
    logic                     acc;
    logic                     wr_room;
    logic                     rd_have;
    logic                     busy;
    logic [NUM_IO:0]          chain_req;
    logic                     en_reject;
    logic                     cmd_push;
    logic                     cmd_pop;
    logic                     rsp_push;
    logic                     rsp_pop;
    logic [APB_DW-1:0]        stat_word;
    logic [APB_DW-1:0]        en_word;
    logic [APB_DW-1:0]        fifo_word;

    sfe_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (paddr),
        .sel  (sel)
    );

    sfe_byte_fifo #(
        .DEPTH  (DEPTH),
        .PUSH_B (BYTES_PER_WORD),
        .POP_B  (1)
    ) u_cmd_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_en   (cmd_push),
        .push_n    (NBW'(sel.nbytes)),
        .push_data (pwdata),
        .pop_en    (cmd_pop),
        .pop_n     (1'b1),
        .peek      (cmd_peek),
        .count     (cmd_cnt)
    );

    sfe_byte_fifo #(
        .DEPTH  (DEPTH),
        .PUSH_B (1),
        .POP_B  (BYTES_PER_WORD)
    ) u_rsp_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_en   (rsp_push),
        .push_n    (1'b1),
        .push_data (rsp_data),
        .pop_en    (rsp_pop),
        .pop_n     (NBW'(sel.nbytes)),
        .peek      (rsp_peek),
        .count     (rsp_cnt)
    );

    // transfer qualification and next-state
    always_comb begin
        st_d = st_q;

        acc       = psel && penable;
        wr_room   = (DEPTH - int'(cmd_cnt)) >= int'(sel.nbytes);
        rd_have   = int'(rsp_cnt) >= int'(sel.nbytes);
        busy      = eng_active || (cmd_cnt != '0);
        chain_req = {pwdata[EN_JTAG_BIT], pwdata[NUM_IO-1:0]};
        en_reject = sel.chains && (busy || !$onehot0(chain_req));

        cmd_push = acc && pwrite && sel.fifo && wr_room;
        rsp_pop  = acc && !pwrite && sel.fifo && rd_have;
        cmd_pop  = cmd_valid && cmd_ready;
        rsp_push = rsp_valid && (int'(rsp_cnt) < DEPTH);

        if (acc && pwrite && sel.stat) begin
            st_d.trst = pwdata[STAT_TRST_BIT];
        end
        if (acc && pwrite && sel.chains && !en_reject) begin
            st_d.io_en   = pwdata[NUM_IO-1:0];
            st_d.jtag_en = pwdata[EN_JTAG_BIT];
        end
        if (rsp_valid && !rsp_push) begin
            st_d.ovf = 1'b1;
        end

        pready  = acc && (!sel.fifo || (pwrite ? wr_room : rd_have));
        pslverr = acc && pwrite && en_reject;
    end

    // read data assembly
    always_comb begin
        stat_word                               = '0;
        stat_word[STAT_ACT_BIT]                 = eng_active;
        stat_word[STAT_CMD_LSB +: STAT_CNT_W]   = STAT_CNT_W'(cmd_cnt);
        stat_word[STAT_RSP_LSB +: STAT_CNT_W]   = STAT_CNT_W'(rsp_cnt);
        stat_word[STAT_TRST_BIT]                = st_q.trst;

        en_word              = '0;
        en_word[NUM_IO-1:0]  = st_q.io_en;
        en_word[EN_JTAG_BIT] = st_q.jtag_en;

        fifo_word = '0;
        for (int k = 0; k < BYTES_PER_WORD; k++) begin
            if (k < int'(sel.nbytes)) begin
                fifo_word[8*k +: 8] = rsp_peek[8*k +: 8];
            end
        end

        if (sel.stat) begin
            prdata = stat_word;
        end else if (sel.chains) begin
            prdata = en_word;
        end else if (sel.fifo) begin
            prdata = fifo_word;
        end else begin
            prdata = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_valid     = (cmd_cnt != '0);
    assign cmd_data      = cmd_peek;
    assign rsp_ovf       = st_q.ovf;
    assign io_chain_en   = st_q.io_en;
    assign jtag_chain_en = st_q.jtag_en;
    assign test_rst_n    = ~(st_q.trst && st_q.jtag_en);

endmodule

// File: rtl/scan_fe_checker.sv
module scan_fe_checker #(
    parameter int DEPTH  = 4,
    parameter int NUM_IO = 4,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              psel,
    input logic              penable,
    input logic              pready,
    input logic              pslverr,
    input logic              eng_active,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [7:0]        cmd_data,
    input logic              rsp_ovf,
    input logic [NUM_IO-1:0] io_chain_en,
    input logic              jtag_chain_en,
    input logic              test_rst_n,
    input logic [CW-1:0]     cmd_cnt,
    input logic [CW-1:0]     rsp_cnt
);

    // R2: an offered byte stays put until taken
    a_r2_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_data)));

    // R4: the command queue never holds more than its depth
    a_r4_cmd_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_cnt <= CW'(DEPTH));

    // R5: the response queue never holds more than its depth
    a_r5_rsp_bound: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_cnt <= CW'(DEPTH));

    // R7: at most one chain enabled
    a_r7_one_chain: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({jtag_chain_en, io_chain_en}));

    // R8: an active engine freezes the chain selection
    a_r8_busy_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        eng_active |=> $stable({jtag_chain_en, io_chain_en}));

    // R8: an error is only signalled on a completing access
    a_r8_err_in_access: assert property (@(posedge clk) disable iff (!rst_n)
        pslverr |-> (pready && psel && penable));

    // R9: no test reset unless the JTAG chain is selected
    a_r9_trst_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !jtag_chain_en |-> test_rst_n);

    // R10: the overflow flag never clears
    a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ovf |=> rsp_ovf);

endmodule

bind scan_fe scan_fe_checker #(.DEPTH(DEPTH), .NUM_IO(NUM_IO)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .psel          (psel),
    .penable       (penable),
    .pready        (pready),
    .pslverr       (pslverr),
    .eng_active    (eng_active),
    .cmd_valid     (cmd_valid),
    .cmd_ready     (cmd_ready),
    .cmd_data      (cmd_data),
    .rsp_ovf       (rsp_ovf),
    .io_chain_en   (io_chain_en),
    .jtag_chain_en (jtag_chain_en),
    .test_rst_n    (test_rst_n),
    .cmd_cnt       (cmd_cnt),
    .rsp_cnt       (rsp_cnt)
);

// File: tb/scan_fe_tb.sv
module scan_fe_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        psel, penable, pwrite;
    logic [7:0]  paddr;
    logic [31:0] pwdata, prdata;
    logic        pready, pslverr;
    logic        eng_active;
    logic        cmd_valid, cmd_ready;
    logic [7:0]  cmd_data;
    logic        rsp_valid;
    logic [7:0]  rsp_data;
    logic        rsp_ovf;
    logic [3:0]  io_chain_en;
    logic        jtag_chain_en;
    logic        test_rst_n;

    int n_checks = 0;
    int n_err    = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    scan_fe u_dut (
        .clk (clk), .rst_n (rst_n),
        .psel (psel), .penable (penable), .pwrite (pwrite), .paddr (paddr),
        .pwdata (pwdata), .prdata (prdata), .pready (pready), .pslverr (pslverr),
        .eng_active (eng_active),
        .cmd_valid (cmd_valid), .cmd_ready (cmd_ready), .cmd_data (cmd_data),
        .rsp_valid (rsp_valid), .rsp_data (rsp_data), .rsp_ovf (rsp_ovf),
        .io_chain_en (io_chain_en), .jtag_chain_en (jtag_chain_en),
        .test_rst_n (test_rst_n)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic apb(input logic wr, input logic [7:0] addr, input logic [31:0] wd,
                       output logic [31:0] rd, output logic err, output int waited);
        @(posedge clk); #1;
        psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = addr; pwdata = wd;
        @(posedge clk); #1;
        penable = 1'b1;
        waited = 0; rd = '0; err = 1'b0;
        forever begin
            @(negedge clk);
            if (pready) begin
                rd  = prdata;
                err = pslverr;
                break;
            end
            waited++;
            if (waited > 200) begin
                n_checks++; n_err++;
                $display("FAIL APB at 0x%02h: actual stalled expected ready", addr);
                break;
            end
        end
        @(posedge clk); #1;
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic wr_chk(input string req, input logic [7:0] addr, input logic [31:0] wd,
                          input logic exp_err);
        logic [31:0] rd; logic err; int w;
        apb(1'b1, addr, wd, rd, err, w);
        check({req, " pslverr"}, {31'b0, err}, {31'b0, exp_err});
    endtask

    task automatic rd_chk(input string req, input logic [7:0] addr, input logic [31:0] exp);
        logic [31:0] rd; logic err; int w;
        apb(1'b0, addr, '0, rd, err, w);
        check(req, rd, exp);
    endtask

    task automatic pop_cmd(input string req, input logic [7:0] exp);
        @(posedge clk); #1;
        cmd_ready = 1'b1;
        @(negedge clk);
        check({req, " cmd_valid"}, {31'b0, cmd_valid}, 32'd1);
        check({req, " cmd_data"}, {24'b0, cmd_data}, {24'b0, exp});
        @(posedge clk); #1;
        cmd_ready = 1'b0;
    endtask

    task automatic push_rsp(input logic [7:0] b);
        @(posedge clk); #1;
        rsp_valid = 1'b1; rsp_data = b;
        @(posedge clk); #1;
        rsp_valid = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 test_rst_n", {31'b0, test_rst_n}, 32'd1);
        check("R1 cmd_valid", {31'b0, cmd_valid}, 32'd0);
        check("R1 rsp_ovf", {31'b0, rsp_ovf}, 32'd0);
        check("R1 chains", {27'b0, jtag_chain_en, io_chain_en}, 32'd0);
        rd_chk("R1 status", 8'h00, 32'h0);
        rd_chk("R1 chain select", 8'h04, 32'h0);
    endtask

    task automatic t_cmd_order();
        wr_chk("R3 write 4", 8'h1C, 32'h44332211, 1'b0);
        rd_chk("R6 cmd count 4", 8'h00, 32'h4000_0000);
        pop_cmd("R3 byte0", 8'h11);
        pop_cmd("R3 byte1", 8'h22);
        pop_cmd("R3 byte2", 8'h33);
        pop_cmd("R2 byte3", 8'h44);
        wr_chk("R3 write 2", 8'h14, 32'hFFFF_BBAA, 1'b0);
        rd_chk("R3 count after 2", 8'h00, 32'h2000_0000);
        pop_cmd("R3 2b lo", 8'hAA);
        pop_cmd("R3 2b hi", 8'hBB);
        wr_chk("R3 write 3", 8'h18, 32'h99CC_DDEE, 1'b0);
        pop_cmd("R3 3b 0", 8'hEE);
        pop_cmd("R3 3b 1", 8'hDD);
        pop_cmd("R3 3b 2", 8'hCC);
        @(negedge clk);
        check("R3 drained", {31'b0, cmd_valid}, 32'd0);
    endtask

    task automatic t_cmd_hold();
        wr_chk("R2 write 1", 8'h10, 32'h0000_005A, 1'b0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R2 hold valid", {31'b0, cmd_valid}, 32'd1);
            check("R2 hold data", {24'b0, cmd_data}, 32'h5A);
        end
        pop_cmd("R2 taken", 8'h5A);
    endtask

    task automatic t_wr_stall();
        logic [31:0] rd; logic err; int w;
        wr_chk("R4 fill 1", 8'h10, 32'h01, 1'b0);
        wr_chk("R4 fill 2", 8'h10, 32'h02, 1'b0);
        wr_chk("R4 fill 3", 8'h10, 32'h03, 1'b0);
        fork
            apb(1'b1, 8'h14, 32'h0000_0504, rd, err, w);
            begin
                repeat (4) @(posedge clk);
                pop_cmd("R4 drain during stall", 8'h01);
            end
        join
        check("R4 stalled", {31'b0, (w >= 3)}, 32'd1);
        rd_chk("R4 whole push", 8'h00, 32'h4000_0000);
        pop_cmd("R4 order 0", 8'h02);
        pop_cmd("R4 order 1", 8'h03);
        pop_cmd("R4 order 2", 8'h04);
        pop_cmd("R4 order 3", 8'h05);
    endtask

    task automatic t_rsp_read();
        logic [31:0] rd; logic err; int w;
        push_rsp(8'hA1); push_rsp(8'hB2); push_rsp(8'hC3);
        rd_chk("R6 rsp count 3", 8'h00, 32'h0300_0000);
        rd_chk("R5 read 2", 8'h14, 32'h0000_B2A1);
        rd_chk("R5 read 1", 8'h10, 32'h0000_00C3);
        fork
            apb(1'b0, 8'h1C, '0, rd, err, w);
            begin
                repeat (3) @(posedge clk);
                push_rsp(8'h11); push_rsp(8'h22); push_rsp(8'h33); push_rsp(8'h44);
            end
        join
        check("R5 read 4 data", rd, 32'h4433_2211);
        check("R5 read stalled", {31'b0, (w >= 6)}, 32'd1);
        check("R10 full without drop", {31'b0, rsp_ovf}, 32'd0);
        rd_chk("R5 emptied", 8'h00, 32'h0);
    endtask

    task automatic t_status();
        @(posedge clk); #1; eng_active = 1'b1;
        rd_chk("R6 active bit", 8'h00, 32'h8000_0000);
        @(posedge clk); #1; eng_active = 1'b0;
        wr_chk("R6 write all", 8'h00, 32'hFFFF_FFFF, 1'b0);
        rd_chk("R6 only trst", 8'h00, 32'h0000_0002);
        @(negedge clk);
        check("R9 no jtag no reset", {31'b0, test_rst_n}, 32'd1);
        wr_chk("R6 clear", 8'h00, 32'h0, 1'b0);
        rd_chk("R6 cleared", 8'h00, 32'h0);
    endtask

    task automatic t_enable();
        wr_chk("R7 jtag", 8'h04, 32'h80, 1'b0);
        rd_chk("R7 jtag rd", 8'h04, 32'h80);
        @(negedge clk);
        check("R7 jtag out", {27'b0, jtag_chain_en, io_chain_en}, 32'h10);
        wr_chk("R7 two chains", 8'h04, 32'h03, 1'b1);
        rd_chk("R7 unchanged", 8'h04, 32'h80);
        wr_chk("R7 upper ignored", 8'h04, 32'hFFFF_FF04, 1'b0);
        rd_chk("R7 io2", 8'h04, 32'h04);
        @(negedge clk);
        check("R7 io2 out", {27'b0, jtag_chain_en, io_chain_en}, 32'h04);
    endtask

    task automatic t_busy();
        @(posedge clk); #1; eng_active = 1'b1;
        wr_chk("R8 active", 8'h04, 32'h01, 1'b1);
        @(posedge clk); #1; eng_active = 1'b0;
        rd_chk("R8 active unchanged", 8'h04, 32'h04);
        wr_chk("R8 queue byte", 8'h10, 32'h77, 1'b0);
        wr_chk("R8 pending", 8'h04, 32'h01, 1'b1);
        rd_chk("R8 pending unchanged", 8'h04, 32'h04);
        pop_cmd("R8 drain", 8'h77);
        wr_chk("R8 idle accept", 8'h04, 32'h01, 1'b0);
        rd_chk("R8 idle value", 8'h04, 32'h01);
    endtask

    task automatic t_trst();
        wr_chk("R9 set ctrl", 8'h00, 32'h2, 1'b0);
        @(negedge clk);
        check("R9 io chain", {31'b0, test_rst_n}, 32'd1);
        wr_chk("R9 pick jtag", 8'h04, 32'h80, 1'b0);
        @(negedge clk);
        check("R9 asserted", {31'b0, test_rst_n}, 32'd0);
        wr_chk("R9 clear ctrl", 8'h00, 32'h0, 1'b0);
        @(negedge clk);
        check("R9 released", {31'b0, test_rst_n}, 32'd1);
        wr_chk("R9 deselect", 8'h04, 32'h0, 1'b0);
    endtask

    task automatic t_overflow();
        for (int i = 1; i <= 5; i++) push_rsp(8'(i));
        @(negedge clk);
        check("R10 flag set", {31'b0, rsp_ovf}, 32'd1);
        rd_chk("R10 count 4", 8'h00, 32'h0400_0000);
        rd_chk("R10 kept first four", 8'h1C, 32'h0403_0201);
        push_rsp(8'h99);
        @(negedge clk);
        check("R10 sticky", {31'b0, rsp_ovf}, 32'd1);
        rd_chk("R10 later byte", 8'h10, 32'h99);
    endtask

    task automatic t_unused();
        logic [31:0] rd; logic err; int w;
        wr_chk("R11 write 0x08", 8'h08, 32'hFFFF_FFFF, 1'b0);
        wr_chk("R11 write 0x0C", 8'h0C, 32'hFFFF_FFFF, 1'b0);
        wr_chk("R11 misaligned", 8'h05, 32'hFFFF_FFFF, 1'b0);
        wr_chk("R11 above map", 8'h24, 32'hFFFF_FFFF, 1'b0);
        apb(1'b0, 8'h08, '0, rd, err, w);
        check("R11 read zero", rd, 32'h0);
        check("R11 no wait", w, 32'd0);
        check("R11 no error", {31'b0, err}, 32'd0);
        rd_chk("R11 read 0x20", 8'h20, 32'h0);
        rd_chk("R11 chains intact", 8'h04, 32'h0);
        rd_chk("R11 status intact", 8'h00, 32'h0);
        @(negedge clk);
        check("R11 cmd queue empty", {31'b0, cmd_valid}, 32'd0);
    endtask

    initial begin
        rst_n = 1'b0; psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
        paddr = '0; pwdata = '0; eng_active = 1'b0; cmd_ready = 1'b0;
        rsp_valid = 1'b0; rsp_data = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_cmd_order();
        t_cmd_hold();
        t_wr_stall();
        t_rsp_read();
        t_status();
        t_enable();
        t_busy();
        t_trst();
        t_overflow();
        t_unused();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_checks++; n_err++;
        $display("FAIL watchdog: actual still running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule